// File: doc/BRIEF.md
# Media integer arithmetic unit

This block is a registered integer execution unit for audio and video primitives. It works on XLEN-bit operands. One operation is presented per cycle with a valid strobe. The unit returns the result one clock later. The operations are:

- rounding average;
- absolute difference, signed or unsigned;
- absolute-difference accumulate into the current destination value, signed or unsigned;
- minimum and maximum, signed or unsigned.

A lane-width select splits the operands into independent 8-, 16- or 32-bit elements, or keeps them whole. When the record bit is set, a four-bit condition field is written from the result. The issuing pipeline supplies the sticky summary-overflow bit, and the unit copies it into the field.

The unit computes the average from a sum one bit wider than the operands, so the carry is never lost. It forms an absolute difference by comparing the operands and then adding the bitwise inverse of the smaller one to the larger one, plus one. The signed and unsigned forms differ only in how that compare treats the top bit.

Top module: `media_alu`

## Requirements
- R1: Opcode 0 (average) returns floor((a+b+1)/2) per element, computed without loss of the carry. For example, all-ones averaged with all-ones gives all-ones.
- R2: Opcodes 1 (signed) and 2 (unsigned) return |a-b| per element, truncated to the element width. The compare is signed for opcode 1 and unsigned for opcode 2. Equal operands give zero.
- R3: Opcodes 3 (signed) and 4 (unsigned) return the destination input plus |a-b| per element. The compare follows R2, and the sum wraps modulo 2^width with no saturation.
- R4: Opcodes 5/6 (signed/unsigned min) return a if a<b, otherwise b. Opcodes 7/8 (signed/unsigned max) return a if a>b, otherwise b.
- R5: The condition output loads only on a valid, legal operation whose record bit is 1. Otherwise it holds its previous value.
- R6: When the condition output loads, it takes the form {negative, positive, zero, so_in}. Exactly one of the upper three bits is set, chosen by a signed compare of the full XLEN result with zero.
- R7: Opcodes 9 to 15 produce a zero result and never update the condition output.
- R8: Lane select 0 treats the operands as one XLEN element. Selects 1, 2 and 3 split them into independent 8-, 16- and 32-bit elements, with element k at bits [k*w +: w]. No carry crosses an element boundary.
- R9: out_valid equals in_valid delayed by one clock. Synchronous active-high reset clears out_valid, out_res and out_cr. The result register loads only when in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| op | input | 4 | Operation code |
| lane | input | 2 | Element width select (0 full, 1 byte, 2 half, 3 word) |
| rec | input | 1 | Record bit: update condition output |
| so_in | input | 1 | Sticky summary-overflow bit copied into the condition field |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand |
| dst_in | input | XLEN | Current destination value for accumulate |
| out_valid | output | 1 | Result valid |
| out_res | output | XLEN | Registered result |
| out_cr | output | 4 | Registered condition field |

## Verification
The bench drives boundary patterns where signed and unsigned ordering disagree, such as the top bit set against a small positive value. Only these patterns tell the two compare variants apart in absolute difference and min/max. All-ones averages and near-wrap accumulates show whether the carry is kept, or dropped as required. The same operands applied at each lane width show whether any carry or borrow leaks across an element boundary. Random operations with random record bits, sticky input and illegal codes exercise the condition hold and the zeroing rule against a behavioural model every clock.

// File: rtl/media_pkg.sv
package media_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned CR_W = 4;

  localparam logic [OP_W-1:0] OP_AVG   = 4'd0;
  localparam logic [OP_W-1:0] OP_ABSDS = 4'd1;
  localparam logic [OP_W-1:0] OP_ABSDU = 4'd2;
  localparam logic [OP_W-1:0] OP_ACCS  = 4'd3;
  localparam logic [OP_W-1:0] OP_ACCU  = 4'd4;
  localparam logic [OP_W-1:0] OP_MINS  = 4'd5;
  localparam logic [OP_W-1:0] OP_MINU  = 4'd6;
  localparam logic [OP_W-1:0] OP_MAXS  = 4'd7;
  localparam logic [OP_W-1:0] OP_MAXU  = 4'd8;

  localparam logic [1:0] LN_FULL = 2'd0;
  localparam logic [1:0] LN_B8   = 2'd1;
  localparam logic [1:0] LN_H16  = 2'd2;
  localparam logic [1:0] LN_W32  = 2'd3;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return code <= OP_MAXU;
  endfunction

  function automatic logic op_is_signed(input logic [OP_W-1:0] code);
    return (code == OP_ABSDS) || (code == OP_ACCS) ||
           (code == OP_MINS)  || (code == OP_MAXS);
  endfunction
endpackage

// File: rtl/media_lane.sv
module media_lane
  import media_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    acc_i,
  output logic [W-1:0]    res_o
);
  function automatic logic f_lt(input logic [W-1:0] x, input logic [W-1:0] y,
                                input logic sgn);
    if (sgn) return $signed(x) < $signed(y);
    return x < y;
  endfunction

  function automatic logic [W-1:0] f_avg(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y} + (W+1)'(1);
    return s[W:1];
  endfunction

  function automatic logic [W-1:0] f_absd(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic x_smaller);
    if (x_smaller) return ~x + y + W'(1);
    return ~y + x + W'(1);
  endfunction

  logic         sgn;
  logic         a_lt_b;
  logic         b_lt_a;
  logic [W-1:0] absd;

  assign sgn    = op_is_signed(op_i);
  assign a_lt_b = f_lt(a_i, b_i, sgn);
  assign b_lt_a = f_lt(b_i, a_i, sgn);
  assign absd   = f_absd(a_i, b_i, a_lt_b);

  always_comb begin
    case (op_i)
      OP_AVG:            res_o = f_avg(a_i, b_i);
      OP_ABSDS, OP_ABSDU: res_o = absd;
      OP_ACCS, OP_ACCU:  res_o = acc_i + absd;
      OP_MINS, OP_MINU:  res_o = a_lt_b ? a_i : b_i;
      OP_MAXS, OP_MAXU:  res_o = b_lt_a ? a_i : b_i;
      default:           res_o = '0;
    endcase
  end

  // R4: min/max never invents a value, it selects one of the operands
  always_comb begin
    if (op_i >= OP_MINS && op_i <= OP_MAXU) begin
      p_minmax_pick_r4 : assert (res_o == a_i || res_o == b_i);
    end
  end
endmodule

// File: rtl/media_lane_array.sv
module media_lane_array
  import media_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned W    = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] acc_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned N_LANES = XLEN / W;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    media_lane #(.W(W)) u_lane (
      .op_i  (op_i),
      .a_i   (a_i[k*W +: W]),
      .b_i   (b_i[k*W +: W]),
      .acc_i (acc_i[k*W +: W]),
      .res_o (res_o[k*W +: W])
    );
  end
endmodule

// File: rtl/media_cond.sv
module media_cond
  import media_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] res_i,
  input  logic            so_i,
  output logic [CR_W-1:0] cr_o
);
  logic is_neg;
  logic is_zero;
  logic is_pos;

  assign is_neg  = res_i[XLEN-1];
  assign is_zero = (res_i == '0);
  assign is_pos  = !is_neg && !is_zero;
  assign cr_o    = {is_neg, is_pos, is_zero, so_i};
endmodule

// File: rtl/media_alu.sv
module media_alu
  import media_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [1:0]      lane,
  input  logic            rec,
  input  logic            so_in,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] dst_in,
  output logic            out_valid,
  output logic [XLEN-1:0] out_res,
  output logic [3:0]      out_cr
);
  localparam int unsigned N_VARIANT = 4;

  initial begin
    p_xlen_ok : assert (XLEN % 32 == 0 && XLEN >= 32);
  end

  // one lane array per element width: full, 8, 16, 32
  logic [XLEN-1:0] var_res [N_VARIANT];

  for (genvar v = 0; v < N_VARIANT; v++) begin : g_var
    localparam int unsigned VW = (v == 0) ? XLEN : (8 << (v - 1));
    media_lane_array #(.XLEN(XLEN), .W(VW)) u_arr (
      .op_i  (op),
      .a_i   (src_a),
      .b_i   (src_b),
      .acc_i (dst_in),
      .res_o (var_res[v])
    );
  end

  logic            legal;
  logic            cr_upd;
  logic [XLEN-1:0] res_nxt;
  logic [CR_W-1:0] cr_nxt;

  assign legal   = op_is_legal(op);
  assign cr_upd  = in_valid && rec && legal;
  assign res_nxt = legal ? var_res[lane] : '0;

  media_cond #(.XLEN(XLEN)) u_cond (
    .res_i (res_nxt),
    .so_i  (so_in),
    .cr_o  (cr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_res <= res_nxt;
      if (cr_upd)   out_cr  <= cr_nxt;
    end
  end

  p_valid_rise_r9 : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r9 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_cr_hold_r5 : assert property (@(posedge clk) disable iff (rst)
    !cr_upd |=> $stable(out_cr));
  p_cr_onehot_r6 : assert property (@(posedge clk) disable iff (rst)
    cr_upd |=> ($countones(out_cr[3:1]) == 1));
  p_cr_so_r6 : assert property (@(posedge clk) disable iff (rst)
    cr_upd |=> (out_cr[0] == $past(so_in)));
  p_illegal_zero_r7 : assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (out_res == '0));
  p_res_hold_r9 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_res));
endmodule

// File: tb/test_media_alu.sv
`timescale 1ns/1ps
module test_media_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  lane;
  logic        rec;
  logic        so_in;
  logic [63:0] src_a, src_b, dst_in;
  logic        out_valid;
  logic [63:0] out_res;
  logic [3:0]  out_cr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_valid;
  logic [63:0] exp_res;
  logic [3:0]  exp_cr;

  always #2 clk = ~clk;

  media_alu #(.XLEN(64)) i_media_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane(lane),
    .rec(rec), .so_in(so_in), .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
    .out_valid(out_valid), .out_res(out_res), .out_cr(out_cr)
  );

  function automatic logic [63:0] model(input int code, input int ln,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    int w;
    logic [63:0] mask, total;
    bit sgn;
    w = (ln == 0) ? 64 : (ln == 1) ? 8 : (ln == 2) ? 16 : 32;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sgn = (code == 1 || code == 3 || code == 5 || code == 7);
    total = '0;
    if (code > 8) return '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic [63:0] ea, eb, ed, hi, lo, r;
      logic [64:0] s;
      bit a_less, b_less;
      ea = (a >> (k * w)) & mask;
      eb = (b >> (k * w)) & mask;
      ed = (d >> (k * w)) & mask;
      if (sgn) begin
        a_less = $signed(ea << (64 - w)) < $signed(eb << (64 - w));
        b_less = $signed(eb << (64 - w)) < $signed(ea << (64 - w));
      end else begin
        a_less = ea < eb;
        b_less = eb < ea;
      end
      hi = a_less ? eb : ea;
      lo = a_less ? ea : eb;
      case (code)
        0: begin s = {1'b0, ea} + {1'b0, eb} + 65'd1; r = s[64:1]; end
        1, 2: r = hi - lo;
        3, 4: r = ed + (hi - lo);
        5, 6: r = a_less ? ea : eb;
        default: r = b_less ? ea : eb;
      endcase
      total = total | ((r & mask) << (k * w));
    end
    return total;
  endfunction

  function automatic string tag_of(input int code, input int ln);
    if (ln != 0) return "R8";
    if (code > 8) return "R7";
    case (code)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input string rtag);
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL R9 valid: actual %0b expected %0b", out_valid, exp_valid);
    end
    checks++;
    if (out_res !== exp_res) begin
      errors++;
      $display("FAIL %s result: actual %h expected %h", rtag, out_res, exp_res);
    end
    checks++;
    if (out_cr !== exp_cr) begin
      errors++;
      $display("FAIL R5/R6 cond: actual %b expected %b", out_cr, exp_cr);
    end
  endtask

  task automatic step(input bit v, input int code, input int ln, input bit r, input bit so,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    string t;
    in_valid = v; op = 4'(code); lane = 2'(ln); rec = r; so_in = so;
    src_a = a; src_b = b; dst_in = d;
    t = tag_of(code, ln);
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      logic [63:0] m;
      m = model(code, ln, a, b, d);
      exp_res = m;
      if (r && code <= 8)
        exp_cr = (m == 0) ? {3'b001, so} : m[63] ? {3'b100, so} : {3'b010, so};
    end
    @(negedge clk);
    compare(t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 0; op = 0; lane = 0; rec = 0; so_in = 0;
    src_a = '0; src_b = '0; dst_in = '0;
    repeat (3) @(negedge clk);
    exp_valid = 0; exp_res = '0; exp_cr = '0;
    compare("R9");
    rst = 1'b0;

    // R1 average, carry kept
    step(1, 0, 0, 1, 0, '1, '1, 0);
    step(1, 0, 0, 1, 0, 64'd3, 64'd4, 0);
    // R2 signed vs unsigned compare, equal gives zero
    step(1, 1, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    step(1, 2, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    step(1, 2, 0, 1, 1, 64'd77, 64'd77, 0);
    // R3 accumulate with wrap
    step(1, 4, 0, 1, 0, 64'd10, 64'd3, '1);
    step(1, 3, 0, 1, 0, -64'sd5, 64'd5, 64'd1);
    // R4 min/max with sign boundary
    step(1, 5, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    step(1, 6, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    step(1, 7, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    step(1, 8, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0);
    // R5 record bit 0 holds condition
    step(1, 1, 0, 0, 1, 64'd0, 64'd9, 0);
    // R7 illegal code: zero result, condition held
    step(1, 12, 0, 1, 1, 64'd5, 64'd6, 0);
    // R9 idle cycle keeps result
    step(0, 0, 0, 1, 0, 64'd1, 64'd1, 0);
    // R8 lane widths with boundary-crossing patterns
    for (int ln = 1; ln < 4; ln++) begin
      for (int c = 0; c < 9; c++)
        step(1, c, ln, 1, 0, 64'h80FF_7F01_00FF_FF80, 64'h017F_80FF_FF00_0180,
             64'hFFFF_FFFF_FFFF_FFFF);
    end
    // random mix
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, $urandom % 11, $urandom % 4, $urandom % 2, $urandom % 2,
           {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    // R9 reset mid-run clears outputs
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_valid = 0; exp_res = '0; exp_cr = '0;
    compare("R9");
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule